// File: doc/BRIEF.md
# Crate Sub-Trigger Hit Summer

This block sits in each crate of a distributed trigger and condenses the hit activity of up to sixteen front-end modules into one 16-bit word for the serial link towards the central trigger. Each front-end module reports its hit count as the width of a single pulse, one cycle of high level per hit. A per-input enable mask chooses which inputs take part. Every enabled input is lengthened by a programmable number of cycles, and the lengthened signals are ORed into the sub-trigger flag.

When the flag goes high while the block is idle, a counting window of a programmed number of cycles opens. The first cycle of the window is the cycle in which the flag rose. For every enabled input, a saturating counter counts the cycles in which that input is high inside the window. When the window closes, the counts are added and the sum is clamped to 12 bits. The result goes out for one cycle as a word tagged as a sub-trigger, together with a valid strobe. At all other times the block outputs a fixed idle word. A new window can open only after the flag has dropped.

Three settings are held in registers: the mask, the stretch length and the window length. Software loads them through a small write port.

Top module: `subtrig_sum_top`

## Requirements
- R1: After reset, `wordOut` is the idle word 16'hF000, `wordValid` is 0 and `subFlag` is 0.
- R2: An input whose mask bit is 0 does not raise `subFlag` and adds nothing to the sum, even when its pulse falls inside a window opened by another input.
- R3: With stretch length S, `subFlag` is high during every cycle in which an enabled input is high and during the S cycles that follow the last such cycle. It is low in the cycle after that.
- R4: A window of W cycles (W of 0 is treated as 1) opens in the first cycle that `subFlag` is high while idle. The window counts inputs from that same cycle through cycle W-1.
- R5: Each input counter holds the number of cycles in which its enabled input was high inside the window, and it saturates at 511.
- R6: The reported sum is the total of all input counts, clamped to 4095.
- R7: If the window opens in cycle 0, then in cycle W+1 (cycle 2 when W is 0 or 1) `wordValid` is high for exactly one cycle and `wordOut` is {4'b0100, sum}.
- R8: In every cycle in which `wordValid` is low, `wordOut` is the idle word {4'b1111, 12'h000}.
- R9: After a word is produced, no new window opens until `subFlag` has been low for at least one cycle. An input that is still high after the window closes therefore produces no second word.
- R10: The write port decodes the address as follows: 0 writes the mask (bit i enables input i), 1 writes the stretch length (bits 5:0), 2 writes the window length (bits 9:0). A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Synchronous reset, active low |
| hitIn | input | 16 | Width-coded hit pulses, one per front-end module, synchronous to clk |
| cfgWrEn | input | 1 | Write strobe for the setting registers |
| cfgAddr | input | 2 | Register select for a write |
| cfgWrData | input | 16 | Write data |
| subFlag | output | 1 | OR of the stretched, enabled hit inputs |
| wordOut | output | 16 | Sub-trigger word, or the idle word |
| wordValid | output | 1 | One-cycle strobe marking a sub-trigger word |

## Verification
The summing path is driven with several patterns. A single input tests the basic count. A staircase of pulse widths across all sixteen inputs shows that each counter is routed to its own input. Half of the inputs masked off shows that the mask acts on counting as well as on the flag. Two far-apart inputs with different widths show that the window follows the first flag cycle rather than any single input. A wide all-input burst separates 12-bit clamping from wrap-around. One very long pulse separates per-counter saturation from sum clamping. A pulse longer than the window shows that the window truncates the count and that the block does not retrigger. Directed cases cover the exact cycle in which the flag falls after stretching, an input that is masked on its own, and a write to the unused address.

// File: rtl/subtrig_pkg.sv
package subtrig_pkg;

  // Strobes from the window control to the datapath
  typedef struct packed {
    logic clearCnt;  // first window cycle: restart counters
    logic countEn;   // inside the window
    logic loadWord;  // present the tagged word next cycle
  } ctrlStrb_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_SUM,
    ST_REARM
  } winState_t;

  localparam logic [3:0] TAG_SUB  = 4'b0100;
  localparam logic [3:0] TAG_IDLE = 4'b1111;

endpackage

// File: rtl/subtrig_ctrl.sv
module subtrig_ctrl
  import subtrig_pkg::*;
#(
  parameter int NUM_IN = 16,
  parameter int DATA_W = 16,
  parameter int WIN_W  = 10,
  parameter int STR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              subFlag,
  output logic [NUM_IN-1:0] inMask,
  output logic [STR_W-1:0]  stretchLen,
  output ctrlStrb_t         strb
);

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_STR  = 2'd1;
  localparam logic [1:0] ADDR_WIN  = 2'd2;
  localparam logic [WIN_W-1:0] WIN_RESET = WIN_W'(32);
  localparam logic [STR_W-1:0] STR_RESET = STR_W'(4);

  logic [WIN_W-1:0] winLen;
  logic [WIN_W-1:0] remQ, remNxt;
  winState_t stateQ, stateNxt;

  // Setting registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMask     <= '1;
      stretchLen <= STR_RESET;
      winLen     <= WIN_RESET;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        ADDR_MASK: inMask     <= cfgWrData[NUM_IN-1:0];
        ADDR_STR:  stretchLen <= cfgWrData[STR_W-1:0];
        ADDR_WIN:  winLen     <= cfgWrData[WIN_W-1:0];
        default:   ;
      endcase
    end
  end

  // Window sequencer
  always_comb begin
    stateNxt = stateQ;
    remNxt   = remQ;
    strb     = '0;
    case (stateQ)
      ST_IDLE: begin
        if (subFlag) begin
          strb.clearCnt = 1'b1;
          strb.countEn  = 1'b1;
          if (winLen <= WIN_W'(1)) begin
            stateNxt = ST_SUM;
          end else begin
            stateNxt = ST_OPEN;
            remNxt   = winLen - WIN_W'(2);
          end
        end
      end
      ST_OPEN: begin
        strb.countEn = 1'b1;
        if (remQ == '0) stateNxt = ST_SUM;
        else            remNxt   = remQ - WIN_W'(1);
      end
      ST_SUM: begin
        strb.loadWord = 1'b1;
        stateNxt = subFlag ? ST_REARM : ST_IDLE;
      end
      ST_REARM: begin
        if (!subFlag) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      remQ   <= '0;
    end else begin
      stateQ <= stateNxt;
      remQ   <= remNxt;
    end
  end

  AST_SINGLE_START: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> !strb.clearCnt) else $error("window restarted back to back"); // R9

  AST_LOAD_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |-> $past(strb.countEn)) else $error("word load without window"); // R4

endmodule

// File: rtl/subtrig_dp.sv
module subtrig_dp
  import subtrig_pkg::*;
#(
  parameter int NUM_IN = 16,
  parameter int CNT_W  = 9,
  parameter int SUM_W  = 12,
  parameter int STR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] hitIn,
  input  logic [NUM_IN-1:0] inMask,
  input  logic [STR_W-1:0]  stretchLen,
  input  ctrlStrb_t         strb,
  output logic              subFlag,
  output logic [SUM_W+3:0]  wordOut,
  output logic              wordValid
);

  localparam int FULL_W = CNT_W + $clog2(NUM_IN) + 1;
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;
  localparam logic [FULL_W-1:0] SUM_CAP = FULL_W'((1 << SUM_W) - 1);

  logic [NUM_IN-1:0]             hitM;
  logic [NUM_IN-1:0]             stretched;
  logic [NUM_IN-1:0][CNT_W-1:0]  cntAll;
  logic [FULL_W-1:0]             fullSum;
  logic [SUM_W-1:0]              satSum;

  assign hitM = hitIn & inMask;

  for (genvar i = 0; i < NUM_IN; i++) begin : gLane
    logic [STR_W-1:0] strCnt;
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN)                strCnt <= '0;
      else if (hitM[i])         strCnt <= stretchLen;
      else if (strCnt != '0)    strCnt <= strCnt - STR_W'(1);
    end

    assign stretched[i] = hitM[i] | (strCnt != '0);

    always_ff @(posedge clk) begin
      if (!rstN)
        cntQ <= '0;
      else if (strb.clearCnt)
        cntQ <= CNT_W'(hitM[i]);
      else if (strb.countEn && hitM[i] && cntQ != CNT_MAX)
        cntQ <= cntQ + CNT_W'(1);
    end

    assign cntAll[i] = cntQ;

    AST_CNT_HOLDS_MAX: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ == CNT_MAX && !strb.clearCnt) |=> cntQ == CNT_MAX) else $error("lane counter wrapped"); // R5
  end

  assign subFlag = |stretched;

  always_comb begin
    fullSum = '0;
    for (int i = 0; i < NUM_IN; i++) fullSum = fullSum + FULL_W'(cntAll[i]);
    satSum = (fullSum > SUM_CAP) ? SUM_CAP[SUM_W-1:0] : fullSum[SUM_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordOut   <= {TAG_IDLE, {SUM_W{1'b0}}};
      wordValid <= 1'b0;
    end else if (strb.loadWord) begin
      wordOut   <= {TAG_SUB, satSum};
      wordValid <= 1'b1;
    end else begin
      wordOut   <= {TAG_IDLE, {SUM_W{1'b0}}};
      wordValid <= 1'b0;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid) else $error("valid longer than one cycle"); // R7

  AST_SUB_TAG: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> wordOut[SUM_W+3:SUM_W] == TAG_SUB) else $error("valid word lacks tag"); // R7

  AST_IDLE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> wordOut == {TAG_IDLE, {SUM_W{1'b0}}}) else $error("idle word corrupted"); // R8

endmodule

// File: rtl/subtrig_sum_top.sv
module subtrig_sum_top
  import subtrig_pkg::*;
#(
  parameter int NUM_IN = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 9,
  parameter int SUM_W  = 12,
  parameter int WIN_W  = 10,
  parameter int STR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] hitIn,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic              subFlag,
  output logic [SUM_W+3:0]  wordOut,
  output logic              wordValid
);

  logic [NUM_IN-1:0] inMask;
  logic [STR_W-1:0]  stretchLen;
  ctrlStrb_t         strb;

  subtrig_ctrl #(
    .NUM_IN(NUM_IN), .DATA_W(DATA_W), .WIN_W(WIN_W), .STR_W(STR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .subFlag(subFlag), .inMask(inMask),
    .stretchLen(stretchLen), .strb(strb)
  );

  subtrig_dp #(
    .NUM_IN(NUM_IN), .CNT_W(CNT_W), .SUM_W(SUM_W), .STR_W(STR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .inMask(inMask),
    .stretchLen(stretchLen), .strb(strb), .subFlag(subFlag),
    .wordOut(wordOut), .wordValid(wordValid)
  );

endmodule

// File: tb/tb_subtrig_sum_top.sv
module tb_subtrig_sum_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] hitIn;
  logic        cfgWrEn;
  logic [1:0]  cfgAddr;
  logic [15:0] cfgWrData;
  logic        subFlag;
  logic [15:0] wordOut;
  logic        wordValid;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  subtrig_sum_top dut (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .cfgWrEn(cfgWrEn),
    .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .subFlag(subFlag),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  typedef struct packed {
    logic [15:0] act;
    logic [15:0] msk;
    logic [9:0]  base;
    logic [3:0]  step;
    logic [9:0]  win;
    logic [5:0]  str;
    logic [11:0] expSum;
  } vec_t;

  // width of input i = base + i*step when act[i] is set
  localparam vec_t VECS [7] = '{
    '{16'h0001, 16'hFFFF, 10'd3,   4'd0, 10'd16,  6'd2, 12'd3},    // R5 single input
    '{16'hFFFF, 16'hFFFF, 10'd1,   4'd1, 10'd20,  6'd4, 12'd136},  // R6 staircase
    '{16'hFFFF, 16'h00FF, 10'd2,   4'd0, 10'd10,  6'd1, 12'd16},   // R2 half masked
    '{16'h8001, 16'hFFFF, 10'd5,   4'd2, 10'd40,  6'd3, 12'd40},   // R4 far inputs
    '{16'hFFFF, 16'hFFFF, 10'd300, 4'd0, 10'd320, 6'd2, 12'd4095}, // R6 clamp
    '{16'h0010, 16'hFFFF, 10'd8,   4'd0, 10'd4,   6'd2, 12'd4},    // R9 truncation
    '{16'h0004, 16'hFFFF, 10'd600, 4'd0, 10'd620, 6'd3, 12'd511}   // R5 lane saturation
  };

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic runVec(input vec_t v, input string req);
    int maxW = 0;
    int extra = 0;
    int wantK;
    for (int i = 0; i < 16; i++)
      if (v.act[i] && int'(v.base) + i * int'(v.step) > maxW) maxW = int'(v.base) + i * int'(v.step);
    wantK = (v.win <= 1) ? 2 : int'(v.win) + 1;
    for (int k = 0; k <= int'(v.win) + int'(v.str) + maxW + 6; k++) begin
      @(negedge clk);
      for (int i = 0; i < 16; i++)
        hitIn[i] = v.act[i] && (k < int'(v.base) + i * int'(v.step));
      #1;
      if (k == wantK) begin
        check16({req, " R7 valid"}, {15'd0, wordValid}, 16'd1);
        check16({req, " R7 word"}, wordOut, {4'b0100, v.expSum});
      end else if (wordValid) begin
        extra++;
      end
    end
    check16({req, " R9 no extra word"}, 16'(extra), 16'd0);
    check16({req, " R8 idle word"}, wordOut, 16'hF000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int extra;
    rstN = 1'b0; hitIn = '0; cfgWrEn = 1'b0; cfgAddr = '0; cfgWrData = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check16("R1 word", wordOut, 16'hF000);
    check16("R1 valid", {15'd0, wordValid}, 16'd0);
    check16("R1 flag", {15'd0, subFlag}, 16'd0);

    // Table walk (R2 R4 R5 R6 R7 R8 R9)
    for (int n = 0; n < 7; n++) begin
      cfgWrite(2'd0, VECS[n].msk);
      cfgWrite(2'd1, {10'd0, VECS[n].str});
      cfgWrite(2'd2, {6'd0, VECS[n].win});
      runVec(VECS[n], $sformatf("vec%0d", n));
    end

    // R3: stretch of 5 after a single-cycle hit
    cfgWrite(2'd0, 16'hFFFF);
    cfgWrite(2'd1, 16'd5);
    cfgWrite(2'd2, 16'd8);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      hitIn = (k == 0) ? 16'h0008 : 16'h0000;
      #1;
      if (k == 5) check16("R3 flag held", {15'd0, subFlag}, 16'd1);
      if (k == 6) check16("R3 flag dropped", {15'd0, subFlag}, 16'd0);
      if (k == 9) check16("R4 window of 8", wordOut, 16'h4001);
    end

    // R2: masked input alone raises nothing
    cfgWrite(2'd0, 16'hFFFE);
    extra = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      hitIn = (k < 4) ? 16'h0001 : 16'h0000;
      #1;
      if (subFlag || wordValid) extra++;
    end
    check16("R2 masked input silent", 16'(extra), 16'd0);

    // R10: write to address 3 leaves the mask alone
    cfgWrite(2'd3, 16'h0000);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      hitIn = (k < 2) ? 16'h0003 : 16'h0000;
      #1;
      if (k == 9) check16("R10 unused address ignored", wordOut, 16'h4002);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule